// File: doc/BRIEF.md
# Two-Word Tuned Phase Generator

This block is the phase-generation core of a numerically controlled oscillator. A parallel write port loads six control registers. Two of them are 32-bit tuning words, and each is written as two 16-bit halves. The other four are 12-bit phase offsets.

On every clock a 32-bit accumulator adds the tuning word picked by `fsel`. The top 12 bits of the accumulator are then offset by the phase word picked by `psel`, and the sum is registered onto `phase_out`. The output frequency is the tuning word times f_clk divided by 2^32. Waveform lookup and conversion happen downstream.

The phase stream is continuous: a new word appears on every clock, and the block accepts no back-pressure. The write port is a plain strobe that cannot be stalled. A write lands at the clock edge where `wr_en` is high.

Top module: `nco_phase_core`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator, both tuning words and all four phase offsets are cleared. `phase_out` reads 0 after that edge, and it stays 0 while no register is written.
- R2: At each edge out of reset, the accumulator advances by tuning word 0 when `fsel`=0 and by tuning word 1 when `fsel`=1.
- R3: `phase_out` after an edge equals accumulator bits [31:20] before that edge plus the selected phase offset, taken modulo 4096.
- R4: `psel`=00 selects offset 0, `psel`=01 selects offset 1, `psel`=10 selects offset 2, and `psel`=11 selects offset 3.
- R5: Write addresses decode as follows: 0 is tuning word 0 bits [15:0]; 1 is tuning word 0 bits [31:16]; 2 is tuning word 1 bits [15:0]; 3 is tuning word 1 bits [31:16]; 4 to 7 are phase offsets 0 to 3.
- R6: Writing one half of a tuning word leaves the other half unchanged.
- R7: A phase offset write stores `wr_data[11:0]`, and bits [15:12] have no effect.
- R8: Changing `fsel` or `psel` does not reset or disturb the accumulator, so the phase stays continuous across a switch.
- R9: A write takes effect at its own edge. An accumulation at that same edge still uses the tuning word that held before the write.
- R10: The accumulator wraps modulo 2^32, and the offset sum wraps modulo 2^12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the register bank |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| fsel | input | 1 | Tuning word select |
| psel | input | 2 | Phase offset select |
| phase_out | output | 12 | Registered phase word |

## Verification
A register write and the accumulation can fall on the same edge. The accumulation must use the old tuning word, and the new word must show up one sample later. The bench provokes this by rewriting the high half of the tuning word that is currently selected while the accumulator is running. The scoreboard model applies the write only after it has computed that edge's accumulation, so any early or late use of the new word shows up as a mismatch on `phase_out`. A select switch on the same edge as a phase offset write is judged the same way.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int ACC_W_D  = 32;
  localparam int PH_W_D   = 12;
  localparam int DATA_W_D = 16;
  localparam int ADDR_W_D = 3;
  localparam int N_FREQ_D = 2;
  localparam int N_PHS_D  = 4;

  // modular add of two phase words of width PH_W_D
  function automatic logic [PH_W_D-1:0] ph_add(input logic [PH_W_D-1:0] a,
                                               input logic [PH_W_D-1:0] b);
    return a + b;
  endfunction
endpackage

// File: rtl/nco_regbank.sv
module nco_regbank #(
  parameter int ACC_W  = nco_pkg::ACC_W_D,
  parameter int PH_W   = nco_pkg::PH_W_D,
  parameter int DATA_W = nco_pkg::DATA_W_D,
  parameter int ADDR_W = nco_pkg::ADDR_W_D,
  parameter int N_FREQ = nco_pkg::N_FREQ_D,
  parameter int N_PHS  = nco_pkg::N_PHS_D
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [N_FREQ-1:0][ACC_W-1:0]     freq_q,
  output logic [N_PHS-1:0][PH_W-1:0]       phase_q
);
  localparam int HALVES  = ACC_W / DATA_W;
  localparam int PH_BASE = N_FREQ * HALVES;

  // tuning words: one register per half-word slot
  for (genvar f = 0; f < N_FREQ; f++) begin : g_freq
    for (genvar h = 0; h < HALVES; h++) begin : g_half
      logic [DATA_W-1:0] half_q;
      always_ff @(posedge clk) begin
        if (rst)
          half_q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(f * HALVES + h))
          half_q <= wr_data;
      end
      assign freq_q[f][h*DATA_W +: DATA_W] = half_q;
    end
  end

  // phase offsets: upper data bits are discarded
  for (genvar p = 0; p < N_PHS; p++) begin : g_phs
    logic [PH_W-1:0] off_q;
    always_ff @(posedge clk) begin
      if (rst)
        off_q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(PH_BASE + p))
        off_q <= wr_data[PH_W-1:0];
    end
    assign phase_q[p] = off_q;
  end
endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int ACC_W  = nco_pkg::ACC_W_D,
  parameter int N_FREQ = nco_pkg::N_FREQ_D,
  localparam int FSEL_W = (N_FREQ > 1) ? $clog2(N_FREQ) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [FSEL_W-1:0]            fsel,
  input  logic [N_FREQ-1:0][ACC_W-1:0] freq_q,
  output logic [ACC_W-1:0]             acc_q
);
  logic [ACC_W-1:0] tw_sel;
  always_comb tw_sel = freq_q[fsel];

  // natural wrap modulo 2^ACC_W
  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_q + tw_sel;
  end
endmodule

// File: rtl/nco_phase_sum.sv
module nco_phase_sum #(
  parameter int PH_W  = nco_pkg::PH_W_D,
  parameter int N_PHS = nco_pkg::N_PHS_D,
  localparam int PSEL_W = (N_PHS > 1) ? $clog2(N_PHS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [PH_W-1:0]            acc_top,
  input  logic [N_PHS-1:0][PH_W-1:0] phase_q,
  input  logic [PSEL_W-1:0]          psel,
  output logic [PH_W-1:0]            phase_out
);
  logic [PH_W-1:0] off_sel;
  always_comb off_sel = phase_q[psel];

  always_ff @(posedge clk) begin
    if (rst) phase_out <= '0;
    else     phase_out <= nco_pkg::ph_add(acc_top, off_sel);
  end
endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core #(
  parameter int ACC_W  = nco_pkg::ACC_W_D,
  parameter int PH_W   = nco_pkg::PH_W_D,
  parameter int DATA_W = nco_pkg::DATA_W_D,
  parameter int ADDR_W = nco_pkg::ADDR_W_D,
  parameter int N_FREQ = nco_pkg::N_FREQ_D,
  parameter int N_PHS  = nco_pkg::N_PHS_D,
  localparam int FSEL_W = (N_FREQ > 1) ? $clog2(N_FREQ) : 1,
  localparam int PSEL_W = (N_PHS > 1) ? $clog2(N_PHS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [FSEL_W-1:0] fsel,
  input  logic [PSEL_W-1:0] psel,
  output logic [PH_W-1:0]   phase_out
);
  logic [N_FREQ-1:0][ACC_W-1:0] freq_q;
  logic [N_PHS-1:0][PH_W-1:0]   phase_q;
  logic [ACC_W-1:0]             acc_q;

  nco_regbank #(
    .ACC_W(ACC_W), .PH_W(PH_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .N_FREQ(N_FREQ), .N_PHS(N_PHS)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .freq_q(freq_q), .phase_q(phase_q)
  );

  nco_accum #(.ACC_W(ACC_W), .N_FREQ(N_FREQ)) u_acc (
    .clk(clk), .rst(rst), .fsel(fsel), .freq_q(freq_q), .acc_q(acc_q)
  );

  nco_phase_sum #(.PH_W(PH_W), .N_PHS(N_PHS)) u_sum (
    .clk(clk), .rst(rst), .acc_top(acc_q[ACC_W-1 -: PH_W]),
    .phase_q(phase_q), .psel(psel), .phase_out(phase_out)
  );
endmodule

// File: rtl/nco_phase_core_chk.sv
module nco_phase_core_chk (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [15:0]      wr_data,
  input logic             fsel,
  input logic [1:0]       psel,
  input logic [11:0]      phase_out,
  input logic [31:0]      acc_q,
  input logic [1:0][31:0] freq_q,
  input logic [3:0][11:0] phase_q
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (phase_out == 12'h000 && acc_q == 32'h0 && freq_q == '0 && phase_q == '0));

  // R2
  acc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> acc_q == $past(acc_q) + $past(freq_q[fsel]));

  // R3
  out_sum_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> phase_out == 12'($past(acc_q[31:20]) + $past(phase_q[psel])));

  // R5
  hi_half_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd1) |=> freq_q[0][31:16] == $past(wr_data));

  // R6
  other_half_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr[2] && !wr_addr[0]) |=>
      freq_q[$past(wr_addr[1])][31:16] == $past(freq_q[wr_addr[1]][31:16]));

  // R7
  phase_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr[2]) |=> phase_q[$past(wr_addr[1:0])] == $past(wr_data[11:0]));
endmodule

bind nco_phase_core nco_phase_core_chk chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .fsel(fsel), .psel(psel), .phase_out(phase_out), .acc_q(acc_q),
  .freq_q(freq_q), .phase_q(phase_q)
);

// File: tb/nco_phase_core_tb_top.sv
module nco_phase_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        fsel = 1'b0;
  logic [1:0]  psel = '0;
  logic [11:0] phase_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [11:0] exp_q[$];
  string       tag_q[$];

  // reference model state
  logic [31:0] m_acc = '0;
  logic [31:0] m_f0 = '0, m_f1 = '0;
  logic [11:0] m_ph[4] = '{default: '0};

  always #10 clk = ~clk;

  nco_phase_core dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fsel(fsel), .psel(psel), .phase_out(phase_out)
  );

  // driver: drive one cycle of inputs, update model, push expected output
  task automatic step(input logic r, input logic we, input logic [2:0] a,
                      input logic [15:0] d, input logic fs, input logic [1:0] ps,
                      input string tag);
    logic [11:0] e;
    @(negedge clk);
    #1;
    rst = r; wr_en = we; wr_addr = a; wr_data = d; fsel = fs; psel = ps;
    if (r) begin
      m_acc = '0; m_f0 = '0; m_f1 = '0;
      foreach (m_ph[i]) m_ph[i] = '0;
      e = '0;
    end else begin
      e = m_acc[31:20] + m_ph[ps];
      m_acc = m_acc + (fs ? m_f1 : m_f0);
      if (we) begin
        case (a)
          3'd0: m_f0[15:0]  = d;
          3'd1: m_f0[31:16] = d;
          3'd2: m_f1[15:0]  = d;
          3'd3: m_f1[31:16] = d;
          default: m_ph[a[1:0]] = d[11:0];
        endcase
      end
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic run(input int n, input logic fs, input logic [1:0] ps, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 3'd0, 16'h0, fs, ps, tag);
  endtask

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [11:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (phase_out !== e) begin
        errors++;
        $display("FAIL %s phase_out got %h exp %h", t, phase_out, e);
      end
    end
  end

  initial begin
    // R1 reset state and idle after reset
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 3'd0, 16'h0, 1'b0, 2'd0, "R1");
    run(3, 1'b0, 2'd0, "R1");
    // R5 / R9 load tuning word 0 high half; the same edge still accumulates 0
    step(1'b0, 1'b1, 3'd1, 16'h0010, 1'b0, 2'd0, "R9");
    step(1'b0, 1'b1, 3'd0, 16'h0000, 1'b0, 2'd0, "R6");
    run(4, 1'b0, 2'd0, "R2");
    // R7 upper bits dropped; R5 phase addresses
    step(1'b0, 1'b1, 3'd4, 16'hF005, 1'b0, 2'd0, "R7");
    step(1'b0, 1'b1, 3'd5, 16'h0123, 1'b0, 2'd1, "R5");
    step(1'b0, 1'b1, 3'd6, 16'hA7FF, 1'b0, 2'd2, "R7");
    step(1'b0, 1'b1, 3'd7, 16'h0ABC, 1'b0, 2'd3, "R5");
    for (int p = 0; p < 4; p++) run(2, 1'b0, 2'(p), "R4");
    // tuning word 1, then switch selects mid-run
    step(1'b0, 1'b1, 3'd3, 16'h0300, 1'b0, 2'd1, "R5");
    step(1'b0, 1'b1, 3'd2, 16'h0000, 1'b0, 2'd0, "R5");
    run(4, 1'b1, 2'd0, "R8");
    run(2, 1'b0, 2'd2, "R8");
    run(2, 1'b1, 2'd3, "R8");
    // R6 low-half write keeps high half
    step(1'b0, 1'b1, 3'd2, 16'hFFFF, 1'b1, 2'd0, "R6");
    run(2, 1'b1, 2'd0, "R6");
    // R9 rewrite the active word while it is in use
    step(1'b0, 1'b1, 3'd3, 16'h0800, 1'b1, 2'd1, "R9");
    run(2, 1'b1, 2'd1, "R9");
    // R10 wrap of accumulator and offset sum
    step(1'b0, 1'b1, 3'd3, 16'hF000, 1'b1, 2'd3, "R10");
    run(40, 1'b1, 2'd3, "R10");
    run(10, 1'b0, 2'd2, "R10");
    // R1 reset mid-run clears everything
    for (int i = 0; i < 2; i++) step(1'b1, 1'b0, 3'd0, 16'h0, 1'b1, 2'd3, "R1");
    run(3, 1'b1, 2'd3, "R1");
    @(negedge clk);
    @(negedge clk);
    #2;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule